// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block is an eight-bit bidirectional I/O port that sits on a microcontroller's internal bus. Software writes an output latch, a per-bit direction register and a pull-up control register at three separate bus addresses. Each pin either drives its latched value or floats as an input, depending on its direction bit. A read of the data address always returns the synchronized level seen on the pins, never the latch.

Other functions can take pins away from general-purpose use. A timer output-compare can own any single pin and force its level. While it does, writes to the data register still land in the latch but have no effect on that pin. When the expanded-bus mode input is high, the whole port carries the upper address byte. The LCD segment enable hands the top four pins to the segment driver, and it does so in either bus mode. Pull-ups are applied only to pins that nothing is driving.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch, the direction register and the pull-up register are all zero. With no peripheral owner active, every pin_oe bit is 0.
- R2: A bus write to address 0 always loads the data latch, even for pins that are inputs or owned by the timer. The new value appears on pin_out once those pins revert to general-purpose outputs.
- R3: A read at address 0 returns pin_in after a two-flop synchronizer. A change on pin_in shows on bus_rdata after exactly two rising clock edges.
- R4: A general-purpose pin (no timer, address or LCD owner) has pin_oe equal to its direction bit. Its pin_out equals its latch bit.
- R5: The direction register at address 1 reads back its stored byte. Address 2 holds the pull-up enable in bit 0 and reads back with bits 7:1 as zero. Address 3 reads as zero.
- R6: While oc_own[i] is 1, pin i (unless the address or LCD function owns it) has pin_oe = 1 and pin_out = oc_val[i], and data writes do not change it. When oc_own[i] clears, the pin returns to its R4 behaviour.
- R7: While mode_expanded is 1, every pin not taken by the LCD has pin_oe = 1 and pin_out equal to addr_hi, whatever the direction bits, latch and timer ownership.
- R8: While lcd_en is 1, pins 7:4 have pin_oe = 1 and pin_out equal to lcd_seg[3:0], in either bus mode. Pins 3:0 are unaffected. LCD has the highest priority, then address, then timer, then general purpose.
- R9: pin_pu[i] is 1 exactly when pull-up bit 0 is 1 and pin_oe[i] is 0.
- R10: A data read returns the pin level and not the latch, even for a pin that is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| mode_expanded | input | 1 | 1 = port carries upper address byte |
| addr_hi | input | 8 | Address bits 15:8 from the bus unit |
| oc_own | input | 8 | Per-pin timer output-compare ownership |
| oc_val | input | 8 | Per-pin timer output-compare level |
| lcd_en | input | 1 | Assign pins 7:4 to LCD segments |
| lcd_seg | input | 4 | LCD segment levels for pins 7:4 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
On every cycle, the assertions check the ownership priority and its effect on pin_oe and pin_out. They also check that no pin has its pull-up on while it is driven, that a data write reaches the latch on the next edge, and the two-edge delay through the synchronizer. Several behaviours span more than one step and only the bench's scenarios can show them. These are a latch write that is hidden by timer ownership and reappears when the timer lets go, the reset contents of the registers, the readback through the bus, and a read that returns the pin rather than the latch on a driven pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PULL = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO  = 2'd0,
    OWN_TIMER = 2'd1,
    OWN_ADDR  = 2'd2,
    OWN_LCD   = 2'd3
  } pin_owner_e;

  function automatic pin_owner_e pick_owner(input logic lcd_pin, input logic expanded,
                                            input logic timer);
    if (lcd_pin)       return OWN_LCD;
    else if (expanded) return OWN_ADDR;
    else if (timer)    return OWN_TIMER;
    else               return OWN_GPIO;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      warm   <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign q = stage2;

  wire sync_ready = (warm == 2'd3);
  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ready |-> (q == $past(d, 2))); // R3
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pins_sync,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic              pull_q,
  output logic [W-1:0]      rdata
);
  wire wr_data = wr && (addr == A_DATA);
  wire wr_dir  = wr && (addr == A_DIR);
  wire wr_pull = wr && (addr == A_PULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
      if (wr_pull) pull_q  <= wdata[0];
    end
  end

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = pins_sync;
      A_DIR:   rdata = dir_q;
      A_PULL:  rdata = {{(W-1){1'b0}}, pull_q};
      default: rdata = '0;
    endcase
  end

  AST_LATCH_ALWAYS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (latch_q == $past(wdata))); // R2
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q)); // R5
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned LCD_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        latch_q,
  input  logic [W-1:0]        dir_q,
  input  logic                mode_expanded,
  input  logic [W-1:0]        addr_hi,
  input  logic [W-1:0]        oc_own,
  input  logic [W-1:0]        oc_val,
  input  logic                lcd_en,
  input  logic [LCD_PINS-1:0] lcd_seg,
  output logic [W-1:0]        pin_out,
  output logic [W-1:0]        pin_oe
);
  localparam int unsigned LCD_BASE = W - LCD_PINS;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic       lcd_here;
    logic       seg_bit;
    pin_owner_e owner;

    if (i >= LCD_BASE) begin : g_lcd
      assign lcd_here = lcd_en;
      assign seg_bit  = lcd_seg[i-LCD_BASE];
    end else begin : g_plain
      assign lcd_here = 1'b0;
      assign seg_bit  = 1'b0;
    end

    assign owner = pick_owner(lcd_here, mode_expanded, oc_own[i]);

    always_comb begin
      unique case (owner)
        OWN_LCD:   begin pin_out[i] = seg_bit;    pin_oe[i] = 1'b1;     end
        OWN_ADDR:  begin pin_out[i] = addr_hi[i]; pin_oe[i] = 1'b1;     end
        OWN_TIMER: begin pin_out[i] = oc_val[i];  pin_oe[i] = 1'b1;     end
        default:   begin pin_out[i] = latch_q[i]; pin_oe[i] = dir_q[i]; end
      endcase
    end

    AST_TIMER_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_own[i] && !mode_expanded && !lcd_here) |-> (pin_oe[i] && pin_out[i] == oc_val[i])); // R6
    AST_ADDR_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_expanded && !lcd_here) |-> (pin_oe[i] && pin_out[i] == addr_hi[i])); // R7
    AST_GPIO_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!oc_own[i] && !mode_expanded && !lcd_here) |-> (pin_oe[i] == dir_q[i] && pin_out[i] == latch_q[i])); // R4
  end

  for (genvar j = LCD_BASE; j < W; j++) begin : g_lcd_chk
    AST_LCD_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |-> (pin_oe[j] && pin_out[j] == lcd_seg[j-LCD_BASE])); // R8
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned LCD_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  input  logic                mode_expanded,
  input  logic [W-1:0]        addr_hi,
  input  logic [W-1:0]        oc_own,
  input  logic [W-1:0]        oc_val,
  input  logic                lcd_en,
  input  logic [LCD_PINS-1:0] lcd_seg,
  input  logic [W-1:0]        pin_in,
  output logic [W-1:0]        pin_out,
  output logic [W-1:0]        pin_oe,
  output logic [W-1:0]        pin_pu
);
  logic [W-1:0] pins_sync;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic         pull_q;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pins_sync(pins_sync), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .rdata(bus_rdata)
  );

  gpio_pinmux #(.W(W), .LCD_PINS(LCD_PINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
    .mode_expanded(mode_expanded), .addr_hi(addr_hi), .oc_own(oc_own), .oc_val(oc_val),
    .lcd_en(lcd_en), .lcd_seg(lcd_seg), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign pin_pu = {W{pull_q}} & ~pin_oe;

  AST_NO_PULL_ON_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R9
  AST_PULL_ON_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (pin_pu == ~pin_oe)); // R9
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       mode_expanded = 1'b0;
  logic [7:0] addr_hi = 8'h00;
  logic [7:0] oc_own = 8'h00;
  logic [7:0] oc_val = 8'h00;
  logic       lcd_en = 1'b0;
  logic [3:0] lcd_seg = 4'h0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_expanded(mode_expanded),
    .addr_hi(addr_hi), .oc_own(oc_own), .oc_val(oc_val), .lcd_en(lcd_en),
    .lcd_seg(lcd_seg), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu)
  );

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] dat;
    logic [7:0] own;
    logic [7:0] ov;
    logic [7:0] ah;
    logic       expd;
    logic       lcd;
    logic [3:0] seg;
    logic [7:0] e_oe;
    logic [7:0] e_out;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'hF0, 8'hA5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 8'hF0, 8'hA5},
    '{8'h0F, 8'h3C, 8'h81, 8'h01, 8'h00, 1'b0, 1'b0, 4'h0, 8'h8F, 8'h3D},
    '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h5A, 1'b1, 1'b0, 4'h0, 8'hFF, 8'h5A},
    '{8'h00, 8'h00, 8'hFF, 8'hC3, 8'h00, 1'b0, 1'b1, 4'h9, 8'hFF, 8'h93},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 1'b1, 1'b1, 4'hE, 8'hFF, 8'hE2},
    '{8'h55, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'h0, 8'hF5, 8'h0F},
    '{8'hFF, 8'hC3, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 8'hFF, 8'hC3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and no drive
    chk("R1 oe", pin_oe, 8'h00);
    read_at(2'd1, rd); chk("R1 dir", rd, 8'h00);
    read_at(2'd2, rd); chk("R1 pull", rd, 8'h00);
    chk("R1 latch via out", pin_out, 8'h00);

    // R5: readbacks
    bus_write(2'd1, 8'h96);
    read_at(2'd1, rd); chk("R5 dir readback", rd, 8'h96);
    bus_write(2'd2, 8'hFF);
    read_at(2'd2, rd); chk("R5 pull readback", rd, 8'h01);
    read_at(2'd3, rd); chk("R5 addr3", rd, 8'h00);

    // Vector table: R4 R6 R7 R8 with R9 pull-up on
    for (int k = 0; k < NV; k++) begin
      bus_write(2'd1, VEC[k].dir);
      bus_write(2'd0, VEC[k].dat);
      @(negedge clk);
      oc_own = VEC[k].own; oc_val = VEC[k].ov; addr_hi = VEC[k].ah;
      mode_expanded = VEC[k].expd; lcd_en = VEC[k].lcd; lcd_seg = VEC[k].seg;
      #0.5;
      chk($sformatf("R4/R6/R7/R8 vec%0d oe", k), pin_oe, VEC[k].e_oe);
      chk($sformatf("R4/R6/R7/R8 vec%0d out", k), pin_out, VEC[k].e_out);
      chk($sformatf("R9 vec%0d pu", k), pin_pu, ~VEC[k].e_oe);
    end
    oc_own = 8'h00; oc_val = 8'h00; mode_expanded = 1'b0; lcd_en = 1'b0; addr_hi = 8'h00;

    // R9: pull-up disabled
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h00);
    @(negedge clk);
    chk("R9 pull off", pin_pu, 8'h00);

    // R2: latch loads while input, visible when switched to output
    bus_write(2'd0, 8'h5E);
    chk("R2 still floating", pin_oe, 8'h00);
    bus_write(2'd1, 8'hFF);
    chk("R2 latch shows", pin_out, 8'h5E);

    // R6: write while timer owns is hidden, appears after release
    @(negedge clk);
    oc_own = 8'h0F; oc_val = 8'h00;
    bus_write(2'd0, 8'hA7);
    chk("R6 timer hides write", pin_out, 8'hA0);
    @(negedge clk);
    oc_own = 8'h00;
    #0.5;
    chk("R6 release shows latch", pin_out, 8'hA7);

    // R7: expanded ignores dir/latch/timer
    @(negedge clk);
    bus_write(2'd1, 8'h00);
    oc_own = 8'hFF; oc_val = 8'h00; mode_expanded = 1'b1; addr_hi = 8'hC9;
    #0.5;
    chk("R7 expanded oe", pin_oe, 8'hFF);
    chk("R7 expanded out", pin_out, 8'hC9);
    @(negedge clk);
    oc_own = 8'h00; mode_expanded = 1'b0;

    // R3: two-edge sync latency
    @(negedge clk);
    bus_addr = 2'd0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h6B;
    @(negedge clk);
    chk("R3 after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R3 after two edges", bus_rdata, 8'h6B);

    // R10: driven pin reads pin level, not latch
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'hFF);
    @(negedge clk);
    pin_in = 8'h12;
    repeat (3) @(negedge clk);
    chk("R10 read is pin", bus_rdata, 8'h12);
    chk("R10 latch drives", pin_out, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule